// File: doc/BRIEF.md
# Channel-Tagged Capture Sample FIFO

This block sits between the decimation filters of a multi-channel microphone capture path and the register read port used by a CPU or DMA engine. Each filter output arrives as a 24-bit sample together with the index of the channel that produced it. The block stores a 32-bit word for each sample. The sample is in the low bits and the channel index is in the top byte. Software can therefore sort interleaved data without tracking the order of arrival. Reads pop one word at a time from a holding port that shows the oldest stored word. This is a show-ahead port.

A six-bit status vector reports the live occupancy as four flags: ready, empty, full and chunk. The chunk flag compares the fill level against a programmable burst size, so that a DMA engine can move a whole burst when the flag is high. Two more flags are sticky errors. Underrun records a read while the FIFO is empty. Overrun records a sample that arrived while the FIFO was full. A status-read strobe clears both errors. A software reset empties the storage and clears the errors.

Control is a three-state occupancy machine with the states ST_EMPTY, ST_PARTIAL and ST_FULL. It has five named transitions:
- T_FILL_FIRST: ST_EMPTY to ST_PARTIAL, on a push.
- T_REACH_FULL: ST_PARTIAL to ST_FULL, on a push without a pop at DEPTH-1 words.
- T_LEAVE_FULL: ST_FULL to ST_PARTIAL, on a pop without a push.
- T_DRAIN_LAST: ST_PARTIAL to ST_EMPTY, on a pop without a push at one word.
- T_FLUSH: any state to ST_EMPTY, on a software reset.

Top module: `tagfifo_rx`

## Requirements
- R1: After reset, status reads 6'b000010 (only empty set) and rd_data reads zero.
- R2: Each word read is {6'b0, channel[1:0], sample[23:0]}: the channel index is in bits [31:24] and the sample in bits [23:0]. Words leave in the order they arrived.
- R3: The FIFO holds 16 words. Full (status bit 2) is set at 16 stored words. 16 consecutive reads from full leave it empty.
- R4: Ready (status bit 0) is set exactly when at least one word is stored. Empty (status bit 1) is set exactly when none is stored. Both follow the occupancy one clock after a push or pop.
- R5: Chunk (status bit 3) is set exactly when the occupancy is at least chunk_cfg. The legal settings are 1, 2, 4 and 8. A setting of 0 behaves as 1. The flag follows a change of chunk_cfg with no clock delay.
- R6: A read while empty sets the sticky underrun flag (status bit 4) on the next clock and pops nothing. A sample written in that same cycle is still stored.
- R7: A sample that arrives while full, with no read in the same cycle, sets the sticky overrun flag (status bit 5). That sample is dropped and the stored words and their order are kept.
- R8: A stat_rd pulse clears underrun and overrun on the next clock. An error event in the same cycle as stat_rd leaves its flag set.
- R9: soft_rst empties the FIFO and clears both error flags on the next clock. It overrides a write, read or status read in the same cycle.
- R10: A read and a write in the same cycle while full are both accepted. The FIFO stays full and no overrun is raised.
- R11: rd_data is zero whenever the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush and error clear |
| wr_valid | input | 1 | A sample is offered this cycle |
| wr_sample | input | 24 | Sample value |
| wr_chan | input | 2 | Index of the source channel |
| rd_en | input | 1 | Pop the holding word |
| rd_data | output | 32 | Oldest stored word, or zero when empty |
| stat_rd | input | 1 | Status read; clears the sticky errors |
| chunk_cfg | input | 4 | Burst threshold in words |
| status | output | 6 | {overrun, underrun, chunk, full, empty, ready} |

## Verification
The latencies differ by flag. Every push, pop, flush and error becomes visible in status and rd_data one clock after the edge that samples it. The chunk flag also reacts to chunk_cfg within the same cycle, with no clock delay. The bench therefore drives inputs just after a rising edge and compares the outputs one unit after the next rising edge, against a queue model that it updates from the requirements. Threshold sweeps change chunk_cfg between edges and compare after a short settle, with no clock in between. The sweeps cover every fill level from 0 to 16 and every threshold from 0 to 8.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

    localparam int unsigned SB_READY = 0;
    localparam int unsigned SB_EMPTY = 1;
    localparam int unsigned SB_FULL  = 2;
    localparam int unsigned SB_CHUNK = 3;
    localparam int unsigned SB_UDR   = 4;
    localparam int unsigned SB_OVR   = 5;
    localparam int unsigned SB_W     = 6;
endpackage

// File: rtl/tagfifo_tag.sv
module tagfifo_tag #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned CHAN_W   = 2,
    parameter int unsigned WORD_W   = 32
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CHAN_W-1:0]   chan,
    output logic [WORD_W-1:0]   word
);
    localparam int unsigned PAD_W = WORD_W - SAMPLE_W - CHAN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, chan, sample};
        end else begin : g_nopad
            assign word = {chan, sample};
        end
    endgenerate
endmodule

// File: rtl/tagfifo_store.sv
module tagfifo_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    assign rd_word = mem[rptr];
endmodule

// File: rtl/tagfifo_ctrl.sv
module tagfifo_ctrl
    import tagfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_valid,
    input  logic             rd_en,
    input  logic             stat_rd,
    input  logic [THR_W-1:0] chunk_cfg,
    output logic             push,
    output logic             pop,
    output logic [SB_W-1:0]  status
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    occ_state_e       state, state_nx;
    logic [CNT_W-1:0] count;
    logic             udr_q, ovr_q;
    logic             udr_evt, ovr_evt;
    logic [THR_W-1:0] thr_eff;

    // Output process: handshakes, events and the status vector.
    always_comb begin
        pop     = rd_en && (state != ST_EMPTY) && !soft_rst;
        push    = wr_valid && ((state != ST_FULL) || pop) && !soft_rst;
        udr_evt = rd_en && (state == ST_EMPTY) && !soft_rst;
        ovr_evt = wr_valid && (state == ST_FULL) && !rd_en && !soft_rst;
        thr_eff = (chunk_cfg == '0) ? THR_W'(1) : chunk_cfg;
        status           = '0;
        status[SB_READY] = (state != ST_EMPTY);
        status[SB_EMPTY] = (state == ST_EMPTY);
        status[SB_FULL]  = (state == ST_FULL);
        status[SB_CHUNK] = (32'(count) >= 32'(thr_eff));
        status[SB_UDR]   = udr_q;
        status[SB_OVR]   = ovr_q;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (push) state_nx = ST_PARTIAL;                       // T_FILL_FIRST
            end
            ST_PARTIAL: begin
                if (push && !pop && count == CNT_LAST)
                    state_nx = ST_FULL;                                // T_REACH_FULL
                else if (pop && !push && count == CNT_W'(1))
                    state_nx = ST_EMPTY;                               // T_DRAIN_LAST
            end
            ST_FULL: begin
                if (pop && !push) state_nx = ST_PARTIAL;               // T_LEAVE_FULL
            end
            default: state_nx = ST_EMPTY;
        endcase
        if (soft_rst) state_nx = ST_EMPTY;                             // T_FLUSH
    end

    // State register with occupancy and sticky errors.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            count <= '0;
            udr_q <= 1'b0;
            ovr_q <= 1'b0;
        end else if (soft_rst) begin
            state <= ST_EMPTY;
            count <= '0;
            udr_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            state <= state_nx;
            count <= count + CNT_W'(push) - CNT_W'(pop);
            udr_q <= udr_evt || (udr_q && !stat_rd);
            ovr_q <= ovr_evt || (ovr_q && !stat_rd);
        end
    end
endmodule

// File: rtl/tagfifo_rx.sv
module tagfifo_rx
    import tagfifo_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned CHAN_W   = 2,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned THR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_sample,
    input  logic [CHAN_W-1:0]   wr_chan,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                stat_rd,
    input  logic [THR_W-1:0]    chunk_cfg,
    output logic [5:0]          status
);
    logic              push, pop;
    logic [WORD_W-1:0] wr_word, rd_word;
    logic [SB_W-1:0]   stat_w;

    tagfifo_tag #(.SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W), .WORD_W(WORD_W)) u_tag (
        .sample (wr_sample),
        .chan   (wr_chan),
        .word   (wr_word)
    );

    tagfifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_valid  (wr_valid),
        .rd_en     (rd_en),
        .stat_rd   (stat_rd),
        .chunk_cfg (chunk_cfg),
        .push      (push),
        .pop       (pop),
        .status    (stat_w)
    );

    tagfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (soft_rst),
        .push    (push),
        .pop     (pop),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

    assign status  = stat_w;
    assign rd_data = stat_w[SB_EMPTY] ? '0 : rd_word;
endmodule

// File: rtl/tagfifo_rx_chk.sv
module tagfifo_rx_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_valid,
    input logic              rd_en,
    input logic              stat_rd,
    input logic [WORD_W-1:0] rd_data,
    input logic [5:0]        status
);
    a_r4_ready_xor_empty: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] != status[1]);

    a_r3_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[0]);

    a_r11_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> rd_data == '0);

    a_r6_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && status[1] && !soft_rst |=> status[4]);

    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && status[2] && !rd_en && !soft_rst |=> status[5]);

    a_r7_overrun_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && status[2] && !rd_en && !soft_rst |=> status[2] && $stable(rd_data));

    a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !soft_rst && !(rd_en && status[1]) && !(wr_valid && status[2] && !rd_en)
        |=> !status[4] && !status[5]);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> status[1] && !status[4] && !status[5]);

    a_r10_full_rw_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && rd_en && status[2] && !status[5] && !soft_rst |=> status[2] && !status[5]);
endmodule

bind tagfifo_rx tagfifo_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_valid (wr_valid),
    .rd_en    (rd_en),
    .stat_rd  (stat_rd),
    .rd_data  (rd_data),
    .status   (status)
);

// File: tb/tb_tagfifo_rx.sv
`timescale 1ns/1ps
module tb_tagfifo_rx;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_sample = '0;
    logic [1:0]  wr_chan = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        stat_rd = 1'b0;
    logic [3:0]  chunk_cfg = 4'd4;
    logic [5:0]  status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model of the queue, built from the requirements
    logic [31:0] mq [DEPTH];
    int          mn = 0;
    logic        m_udr = 1'b0, m_ovr = 1'b0;

    always #5 clk = ~clk;

    tagfifo_rx dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_valid(wr_valid),
        .wr_sample(wr_sample), .wr_chan(wr_chan), .rd_en(rd_en), .rd_data(rd_data),
        .stat_rd(stat_rd), .chunk_cfg(chunk_cfg), .status(status)
    );

    function automatic logic [23:0] samp(int i);
        return 24'(i * 32'h0001_3579 + 32'h00A0_0001);
    endfunction

    function automatic logic [31:0] mkword(logic [1:0] ch, logic [23:0] s);
        return {6'b0, ch, s};
    endfunction

    function automatic logic [5:0] exp_status();
        int thr;
        thr = (chunk_cfg == 0) ? 1 : int'(chunk_cfg);
        return {m_ovr, m_udr, (mn >= thr), (mn == DEPTH), (mn == 0), (mn != 0)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        check(req, 32'(status), 32'(exp_status()));
        check(req, rd_data, (mn == 0) ? 32'h0 : mq[0]);
    endtask

    // One clock cycle: drive, update model, then compare after the edge
    task automatic cyc(string req, bit wv, logic [23:0] s, logic [1:0] ch,
                       bit rd, bit srd, bit srst);
        bit p, ue, acc, oe;
        wr_valid = wv; wr_sample = s; wr_chan = ch;
        rd_en = rd; stat_rd = srd; soft_rst = srst;
        if (srst) begin
            mn = 0; m_udr = 1'b0; m_ovr = 1'b0;
        end else begin
            p   = rd && (mn > 0);
            ue  = rd && (mn == 0);
            acc = wv && ((mn < DEPTH) || p);
            oe  = wv && (mn == DEPTH) && !rd;
            if (p) begin
                for (int k = 0; k < DEPTH - 1; k++) mq[k] = mq[k+1];
                mn--;
            end
            if (acc) begin
                mq[mn] = mkword(ch, s);
                mn++;
            end
            m_udr = ue || (m_udr && !srd);
            m_ovr = oe || (m_ovr && !srd);
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0; rd_en = 1'b0; stat_rd = 1'b0; soft_rst = 1'b0;
        check_outputs(req);
    endtask

    task automatic sweep_chunk();
        for (int c = 0; c <= 8; c++) begin
            chunk_cfg = 4'(c);
            #1;
            check("R5 chunk threshold", 32'(status), 32'(exp_status()));
        end
        chunk_cfg = 4'd4;
        #1;
    endtask

    initial begin
        #100us;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 reset status", 32'(status), 32'h2);
        check("R1 reset data", rd_data, 32'h0);
        sweep_chunk();

        // R3 / R4 / R2: fill to 16 with rotating channels
        for (int i = 0; i < DEPTH; i++) begin
            cyc("R4 fill", 1'b1, samp(i), 2'(i % 4), 1'b0, 1'b0, 1'b0);
            sweep_chunk();
        end
        check("R3 full after 16", 32'(status[2]), 32'h1);

        // R7 overrun drops the sample, keeps head
        cyc("R7 overrun", 1'b1, 24'hDEAD01, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R7 overrun flag", 32'(status[5]), 32'h1);
        // R8 status read clears
        cyc("R8 clear", 1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
        // R10 read and write at full
        cyc("R10 full rw", 1'b1, samp(16), 2'd2, 1'b1, 1'b0, 1'b0);
        check("R10 no overrun", 32'(status[5]), 32'h0);

        // R2 / R3 drain all 16 in order
        for (int i = 0; i < DEPTH; i++) begin
            cyc("R2 drain order", 1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
            sweep_chunk();
        end
        check("R3 empty after 16 reads", 32'(status[1]), 32'h1);

        // R6 / R11 underrun
        cyc("R6 underrun", 1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
        check("R11 zero when empty", rd_data, 32'h0);
        // R8 event and status read together keeps the flag
        cyc("R8 event wins", 1'b0, '0, '0, 1'b1, 1'b1, 1'b0);
        check("R8 underrun kept", 32'(status[4]), 32'h1);
        cyc("R8 clear udr", 1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
        // R6 read and write on empty: underrun and the write is stored
        cyc("R6 rw on empty", 1'b1, 24'hFFFFFF, 2'd3, 1'b1, 1'b0, 1'b0);
        check("R2 tag max", rd_data, 32'h03FF_FFFF);

        // R9 fill, overrun, then flush with a concurrent write
        for (int i = 0; i < DEPTH - 1; i++)
            cyc("R4 refill", 1'b1, samp(40 + i), 2'(i % 4), 1'b0, 1'b0, 1'b0);
        cyc("R7 overrun again", 1'b1, 24'h123456, 2'd1, 1'b0, 1'b0, 1'b0);
        cyc("R9 flush", 1'b1, 24'h0BADF0, 2'd2, 1'b1, 1'b1, 1'b1);
        check("R9 flushed", 32'(status), 32'h2);

        // After the flush, the FIFO works normally
        for (int i = 0; i < 4; i++)
            cyc("R2 post flush", 1'b1, samp(80 + i), 2'(3 - i), 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++)
            cyc("R2 post flush read", 1'b0, '0, '0, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule